// File: doc/BRIEF.md
# Configurable SPI Slave Shifter

This block is the slave end of a serial peripheral link. An external master drives a serial clock, an active-low select and a data line. The block moves one data word in each direction per frame. The frame is 8 or 16 bits long. Bits go most significant first or least significant first, and either clock phase is supported. The serial clock is never used as a clock inside the block. The pad signals pass through a synchronizer into the system clock domain, and both transitions of the serial clock are counted from the start of each frame. Each count is sorted into a latch edge or a shift edge. On a latch edge the incoming bit is captured. On a shift edge the captured bit is moved into the shift register and the next outgoing bit is presented.

The host side loads a transmit word with a one-cycle strobe. It collects finished frames from a receive register that carries a full flag, and a read strobe clears that flag. The block has two data pins. The primary input pin takes serial data in. The second pin is bidirectional and normally carries serial data out. In single-wire mode both directions use that second pin, and an enable input picks whether the block drives the pin or listens on it. The system clock must run at least four times faster than the serial clock.

Top module: `spi_slave_shifter`

## Requirements
- R1: While `ser_sel_n` is 1, `pad_io_oe` is 0 and serial clock transitions neither shift nor complete a frame. Deasserting select in the middle of a frame throws away the partial frame. The next selection starts again from the first bit of the transmit word, and the abandoned bits never reach `rx_data`.
- R2: With `cfg_cpha`=0, the 1st, 3rd, 5th and later odd transitions of the serial clock after select falls capture the input bit. The even transitions shift it in and present the next outgoing bit.
- R3: With `cfg_cpha`=1, the odd transitions present an outgoing bit and the even transitions capture the input bit. The final even transition of a frame also commits that last bit.
- R4: With `cfg_cpha`=0, the first outgoing bit is on `pad_io_out` once select has been low for the synchronizer latency, before any serial clock transition.
- R5: With `cfg_cpha`=1, `pad_io_out` is 0 after select falls until the first serial clock transition, which puts the first outgoing bit on the pin.
- R6: When `cfg_lsb_first`=1, bit 0 of the word is sent first and the first received bit ends up in bit 0. When it is 0, the top bit of the frame (bit 15 or bit 7) is sent first and the first received bit lands in that top bit.
- R7: A frame completes after 16 shifts when `cfg_wide`=1 and after 8 when it is 0. On completion the received word is written to `rx_data` and `rx_full` goes to 1.
- R8: When `cfg_single_wire`=0, data enters on `pad_din` and leaves on `pad_io_out`. When `cfg_single_wire`=1, data enters from `pad_io_in`. In that mode `pad_io_oe` is 1 only when `cfg_bidi_oe`=1 and select is low, and `pad_din` is ignored.
- R9: A one-cycle pulse on `rx_read` clears `rx_full` and leaves `rx_data` unchanged. If a frame completes in the same cycle, `rx_full` stays set.
- R10: The transmit word, loaded by `tx_load`, is copied into the shift register when select falls. It is copied again at every frame boundary while select stays low, so a word loaded during a frame goes out in the next frame.
- R11: After an 8-bit frame, bits 15 to 8 of `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 = 16-bit frame, 0 = 8-bit frame |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_single_wire | input | 1 | 1 = both directions use the bidirectional pin |
| cfg_bidi_oe | input | 1 | Drive enable for the bidirectional pin in single-wire mode |
| ser_clk | input | 1 | Serial clock from the master |
| ser_sel_n | input | 1 | Active-low slave select |
| pad_din | input | 1 | Primary serial data input pin |
| pad_io_in | input | 1 | Value seen on the bidirectional pin |
| pad_io_out | output | 1 | Value driven on the bidirectional pin |
| pad_io_oe | output | 1 | Drive enable of the bidirectional pin |
| tx_load | input | 1 | Strobe that loads `tx_data` into the transmit register |
| tx_data | input | 16 | Transmit word |
| rx_read | input | 1 | Read strobe that clears `rx_full` |
| rx_data | output | 16 | Last received word |
| rx_full | output | 1 | A new word is waiting in `rx_data` |

## Verification
The hardest states to reach from the ports are a frame abandoned part way through and a second frame that follows the first with no deselect between them. In both, stale shift state or a stale bit count would corrupt the next word. The master model in the bench can stop after any number of clock transitions, and it then toggles the clock while the block is deselected. Back-to-back frames are run inside a single selection, with a new transmit word loaded while the first frame is still in flight. The scoreboard catches a frame that was completed when it should have been abandoned and a word that was not reloaded.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

   // Role of one observed serial clock transition.
   typedef enum logic [1:0] {
      EDGE_NONE  = 2'd0,
      EDGE_LATCH = 2'd1,
      EDGE_SHIFT = 2'd2
   } edge_role_e;

   // Odd transitions capture when the phase is 0, even transitions when it is 1.
   function automatic edge_role_e classify_edge(input logic seen,
                                                input logic odd,
                                                input logic cpha);
      if (!seen) return EDGE_NONE;
      return (odd ^ cpha) ? EDGE_LATCH : EDGE_SHIFT;
   endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int unsigned     WIDTH   = 3,
   parameter int unsigned     STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_slv_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("spi_slv_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RST_VAL;
            else        stage_q[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[i] <= RST_VAL;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_slv_pinmux.sv
module spi_slv_pinmux (
   input  logic single_wire,
   input  logic bidi_oe,
   input  logic sel_n_raw,
   input  logic sdo,
   input  logic pad_din,
   input  logic pad_io_in,
   output logic raw_din,
   output logic pad_io_out,
   output logic pad_io_oe
);

   always_comb begin
      raw_din    = single_wire ? pad_io_in : pad_din;
      // Gated from the raw pin so deselect releases the line with no sync delay.
      pad_io_oe  = !sel_n_raw && (!single_wire || bidi_oe);
      pad_io_out = pad_io_oe ? sdo : 1'b0;
   end

endmodule

// File: rtl/spi_slv_core.sv
module spi_slv_core
   import spi_slv_pkg::*;
#(
   parameter int unsigned MAX_W    = 16,
   parameter int unsigned NARROW_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wide,
   input  logic             cfg_lsb_first,
   input  logic             cfg_cpha,
   input  logic             sel_act,
   input  logic             sclk_s,
   input  logic             din_s,
   input  logic             tx_load,
   input  logic [MAX_W-1:0] tx_data,
   input  logic             rx_read,
   output logic [MAX_W-1:0] rx_data,
   output logic             rx_full,
   output logic             sdo
);

   localparam int unsigned      CW          = $clog2(MAX_W + 1);
   localparam logic [MAX_W-1:0] NARROW_MASK = {{(MAX_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   function automatic logic [MAX_W-1:0] push_bit(input logic [MAX_W-1:0] s,
                                                 input logic b,
                                                 input logic lsbf,
                                                 input logic wide);
      logic [MAX_W-1:0] r;
      if (!lsbf) begin
         r = {s[MAX_W-2:0], b};
      end else begin
         r = s >> 1;
         if (wide) r[MAX_W-1]    = b;
         else      r[NARROW_W-1] = b;
      end
      return r;
   endfunction

   function automatic logic pick_out(input logic [MAX_W-1:0] s,
                                     input logic lsbf,
                                     input logic wide);
      if (lsbf) return s[0];
      return wide ? s[MAX_W-1] : s[NARROW_W-1];
   endfunction

   logic [MAX_W-1:0] tx_reg, shreg, sh_shift;
   logic [CW-1:0]    bit_cnt, frame_len;
   logic             sclk_d, sel_d, edge_odd, pending, latch_q, sdo_q;
   logic             edge_seen, last_bit, done_c, commit_bit;
   edge_role_e       role;

   always_comb begin
      edge_seen  = sel_act && sel_d && (sclk_s != sclk_d);
      role       = classify_edge(edge_seen, edge_odd, cfg_cpha);
      frame_len  = cfg_wide ? CW'(MAX_W) : CW'(NARROW_W);
      last_bit   = (bit_cnt == frame_len - CW'(1));
      done_c     = last_bit && ((role == EDGE_SHIFT && !cfg_cpha) ||
                                (role == EDGE_LATCH &&  cfg_cpha));
      commit_bit = (role == EDGE_LATCH) ? din_s : latch_q;
      sh_shift   = push_bit(shreg, commit_bit, cfg_lsb_first, cfg_wide);
   end

   assign sdo = cfg_cpha ? sdo_q : pick_out(shreg, cfg_lsb_first, cfg_wide);

   // Host side registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_reg  <= '0;
         rx_data <= '0;
         rx_full <= 1'b0;
      end else begin
         if (tx_load) tx_reg <= tx_data;
         if (done_c) begin
            rx_data <= cfg_wide ? sh_shift : (sh_shift & NARROW_MASK);
            rx_full <= 1'b1;
         end else if (rx_read) begin
            rx_full <= 1'b0;
         end
      end
   end

   // Serial sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         sel_d    <= 1'b0;
         edge_odd <= 1'b1;
         pending  <= 1'b0;
         latch_q  <= 1'b0;
         sdo_q    <= 1'b0;
         bit_cnt  <= '0;
         shreg    <= '0;
      end else begin
         sclk_d <= sclk_s;
         sel_d  <= sel_act;
         if (!sel_act) begin
            bit_cnt  <= '0;
            edge_odd <= 1'b1;
            pending  <= 1'b0;
            sdo_q    <= 1'b0;
         end else if (!sel_d) begin
            shreg    <= tx_reg;
            bit_cnt  <= '0;
            edge_odd <= 1'b1;
            pending  <= 1'b0;
            sdo_q    <= 1'b0;
         end else if (role != EDGE_NONE) begin
            edge_odd <= !edge_odd;
            if (done_c) begin
               shreg   <= tx_reg;
               bit_cnt <= '0;
               pending <= 1'b0;
            end else if (role == EDGE_LATCH) begin
               latch_q <= din_s;
               pending <= 1'b1;
            end else begin
               if (pending) begin
                  shreg   <= sh_shift;
                  bit_cnt <= bit_cnt + CW'(1);
                  pending <= 1'b0;
               end
               if (cfg_cpha)
                  sdo_q <= pick_out(pending ? sh_shift : shreg, cfg_lsb_first, cfg_wide);
            end
         end
      end
   end

   assert_idle_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_act |=> (bit_cnt == '0 && !pending));

   assert_full_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_c |=> rx_full);

   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sel_act |-> (bit_cnt < frame_len));

   assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_c && !cfg_wide) |=> (rx_data[MAX_W-1:NARROW_W] == '0));

   assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_read && !done_c) |=> !rx_full);

   assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done_c |=> $stable(rx_data));

endmodule

// File: rtl/spi_slave_shifter.sv
module spi_slave_shifter #(
   parameter int unsigned MAX_W       = 16,
   parameter int unsigned NARROW_W    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wide,
   input  logic             cfg_lsb_first,
   input  logic             cfg_cpha,
   input  logic             cfg_single_wire,
   input  logic             cfg_bidi_oe,
   input  logic             ser_clk,
   input  logic             ser_sel_n,
   input  logic             pad_din,
   input  logic             pad_io_in,
   output logic             pad_io_out,
   output logic             pad_io_oe,
   input  logic             tx_load,
   input  logic [MAX_W-1:0] tx_data,
   input  logic             rx_read,
   output logic [MAX_W-1:0] rx_data,
   output logic             rx_full
);

   if (NARROW_W < 2 || NARROW_W >= MAX_W) begin : g_bad_frame
      $error("spi_slave_shifter: need 2 <= NARROW_W < MAX_W");
   end

   localparam int unsigned SYNC_W = 3;

   logic              raw_din, sdo;
   logic [SYNC_W-1:0] raw_vec, sync_vec;

   spi_slv_pinmux u_pinmux (
      .single_wire (cfg_single_wire),
      .bidi_oe     (cfg_bidi_oe),
      .sel_n_raw   (ser_sel_n),
      .sdo         (sdo),
      .pad_din     (pad_din),
      .pad_io_in   (pad_io_in),
      .raw_din     (raw_din),
      .pad_io_out  (pad_io_out),
      .pad_io_oe   (pad_io_oe)
   );

   assign raw_vec = {ser_sel_n, ser_clk, raw_din};

   spi_slv_sync #(
      .WIDTH   (SYNC_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_vec),
      .q     (sync_vec)
   );

   spi_slv_core #(
      .MAX_W    (MAX_W),
      .NARROW_W (NARROW_W)
   ) u_core (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_wide      (cfg_wide),
      .cfg_lsb_first (cfg_lsb_first),
      .cfg_cpha      (cfg_cpha),
      .sel_act       (~sync_vec[2]),
      .sclk_s        (sync_vec[1]),
      .din_s         (sync_vec[0]),
      .tx_load       (tx_load),
      .tx_data       (tx_data),
      .rx_read       (rx_read),
      .rx_data       (rx_data),
      .rx_full       (rx_full),
      .sdo           (sdo)
   );

   assert_sel_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ser_sel_n |-> !pad_io_oe);

   assert_listen_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_single_wire && !cfg_bidi_oe) |-> !pad_io_oe);

endmodule

// File: tb/spi_slave_shifter_bench.sv
module spi_slave_shifter_bench;
   localparam int DW = 16;
   localparam int H  = 6;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n;
   logic cfg_wide, cfg_lsb_first, cfg_cpha, cfg_single_wire, cfg_bidi_oe;
   logic ser_clk, ser_sel_n, pad_din, io_drv;
   logic pad_io_in, pad_io_out, pad_io_oe;
   logic tx_load;
   logic [DW-1:0] tx_data, rx_data;
   logic rx_full, rx_read;
   logic mon_rd = 1'b0;
   logic tst_rd;
   logic mon_en;

   int checks = 0;
   int failures = 0;
   logic [DW-1:0] exp_q[$];
   string         tag_q[$];
   logic [DW-1:0] mon_e;
   string         mon_t;

   assign rx_read   = mon_rd | tst_rd;
   assign pad_io_in = pad_io_oe ? pad_io_out : io_drv;

   spi_slave_shifter u_spi_slave_shifter (
      .clk(clk), .rst_n(rst_n),
      .cfg_wide(cfg_wide), .cfg_lsb_first(cfg_lsb_first), .cfg_cpha(cfg_cpha),
      .cfg_single_wire(cfg_single_wire), .cfg_bidi_oe(cfg_bidi_oe),
      .ser_clk(ser_clk), .ser_sel_n(ser_sel_n), .pad_din(pad_din),
      .pad_io_in(pad_io_in), .pad_io_out(pad_io_out), .pad_io_oe(pad_io_oe),
      .tx_load(tx_load), .tx_data(tx_data), .rx_read(rx_read),
      .rx_data(rx_data), .rx_full(rx_full)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   // Scoreboard monitor: pops expected words as frames complete
   always @(negedge clk) begin
      if (mon_rd) begin
         mon_rd <= 1'b0;
      end else if (mon_en && rx_full) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected frame", rx_data, 0);
         end else begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            chk(rx_data == mon_e, mon_t, "received word", rx_data, mon_e);
         end
         mon_rd <= 1'b1;
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_tx(input logic [DW-1:0] v);
      @(negedge clk); tx_data = v; tx_load = 1'b1;
      @(negedge clk); tx_load = 1'b0;
   endtask

   task automatic sel_lo();
      @(negedge clk); ser_sel_n = 1'b0;
      wait_clk(H);
   endtask

   task automatic sel_hi();
      @(negedge clk); ser_sel_n = 1'b1;
      wait_clk(H);
   endtask

   function automatic logic order_bit(input logic [DW-1:0] w, input int n,
                                      input logic lsbf, input int i);
      return lsbf ? w[i] : w[n-1-i];
   endfunction

   task automatic put_bit(input logic b, input logic on_io);
      if (on_io) begin io_drv = b; pad_din = ~b; end
      else       begin pad_din = b; io_drv = ~b; end
   endtask

   // Master model: runs nedges transitions, captures the slave's output bits
   task automatic frame(input logic [DW-1:0] mw, input int n, input int nedges,
                        input logic on_io, output logic [DW-1:0] got);
      got = '0;
      if (!cfg_cpha) put_bit(order_bit(mw, n, cfg_lsb_first, 0), on_io);
      for (int k = 1; k <= nedges; k++) begin
         wait_clk(H);
         if ((k % 2 == 1) != cfg_cpha) begin
            int idx;
            idx = (k - 1) / 2;
            if (cfg_lsb_first) got[idx] = pad_io_out;
            else               got[n-1-idx] = pad_io_out;
         end
         ser_clk = ~ser_clk;
         if (cfg_cpha && (k % 2 == 1))
            put_bit(order_bit(mw, n, cfg_lsb_first, (k - 1) / 2), on_io);
         else if (!cfg_cpha && (k % 2 == 0) && (k / 2 < n))
            put_bit(order_bit(mw, n, cfg_lsb_first, k / 2), on_io);
      end
      wait_clk(H);
   endtask

   task automatic xact(input logic [DW-1:0] mw, input int n, input logic [DW-1:0] exp_out,
                       input logic [DW-1:0] exp_rx, input string tag);
      logic [DW-1:0] got;
      exp_q.push_back(exp_rx); tag_q.push_back(tag);
      sel_lo();
      frame(mw, n, 2 * n, 1'b0, got);
      sel_hi();
      chk(got == exp_out, tag, "serial output word", got, exp_out);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog R7 act=timeout exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [DW-1:0] g1, g2;
      rst_n = 1'b0; mon_en = 1'b1; tst_rd = 1'b0;
      cfg_wide = 1'b1; cfg_lsb_first = 1'b0; cfg_cpha = 1'b0;
      cfg_single_wire = 1'b0; cfg_bidi_oe = 1'b0;
      ser_clk = 1'b0; ser_sel_n = 1'b1; pad_din = 1'b0; io_drv = 1'b0;
      tx_load = 1'b0; tx_data = '0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);

      // Reset state
      chk(rx_full == 1'b0, "R9", "rx_full after reset", rx_full, 0);
      chk(rx_data == '0, "R7", "rx_data after reset", rx_data, 0);
      chk(pad_io_oe == 1'b0, "R1", "pin released while deselected", pad_io_oe, 0);

      // R2 / R7: 16-bit, phase 0, MSB first
      load_tx(16'hC3A5);
      xact(16'hBEEF, 16, 16'hC3A5, 16'hBEEF, "R2");

      // R11 / R4: 8-bit after a 16-bit word with a set upper byte
      cfg_wide = 1'b0;
      load_tx(16'hFFA5);
      exp_q.push_back(16'h003C); tag_q.push_back("R11");
      sel_lo();
      chk(pad_io_oe == 1'b1, "R1", "pin driven while selected", pad_io_oe, 1);
      chk(pad_io_out == 1'b1, "R4", "first bit before any edge", pad_io_out, 1);
      frame(16'h003C, 8, 16, 1'b0, g1);
      sel_hi();
      chk(g1 == 16'h00A5, "R2", "8-bit serial output", g1, 16'h00A5);

      // R3 / R5: phase 1
      cfg_cpha = 1'b1;
      load_tx(16'h0081);
      exp_q.push_back(16'h005A); tag_q.push_back("R3");
      sel_lo();
      chk(pad_io_out == 1'b0, "R5", "output quiet before first edge", pad_io_out, 0);
      frame(16'h005A, 8, 16, 1'b0, g1);
      sel_hi();
      chk(g1 == 16'h0081, "R5", "phase 1 serial output", g1, 16'h0081);

      // R6: LSB first, both widths and phases
      cfg_lsb_first = 1'b1; cfg_wide = 1'b1;
      load_tx(16'h1234);
      xact(16'h8001, 16, 16'h1234, 16'h8001, "R6");
      cfg_cpha = 1'b0; cfg_wide = 1'b0;
      load_tx(16'h0001);
      xact(16'h0080, 8, 16'h0001, 16'h0080, "R6");

      // R9: read strobe clears the flag, data held
      cfg_lsb_first = 1'b0;
      mon_en = 1'b0;
      load_tx(16'h00F0);
      sel_lo();
      frame(16'h0069, 8, 16, 1'b0, g1);
      chk(rx_full == 1'b1, "R7", "flag set on completion", rx_full, 1);
      chk(rx_data == 16'h0069, "R7", "received word", rx_data, 16'h0069);
      @(negedge clk); tst_rd = 1'b1;
      @(negedge clk); tst_rd = 1'b0;
      wait_clk(2);
      chk(rx_full == 1'b0, "R9", "flag cleared by read", rx_full, 0);
      chk(rx_data == 16'h0069, "R9", "data kept after read", rx_data, 16'h0069);
      sel_hi();
      mon_en = 1'b1;

      // R1: abort mid-frame, edges while deselected, then a clean frame
      load_tx(16'h00AA);
      sel_lo();
      frame(16'h00FF, 8, 5, 1'b0, g1);
      @(negedge clk); ser_sel_n = 1'b1;
      @(negedge clk);
      chk(pad_io_oe == 1'b0, "R1", "pin released on deselect", pad_io_oe, 0);
      for (int j = 0; j < 6; j++) begin
         wait_clk(H);
         ser_clk = ~ser_clk;
      end
      wait_clk(H);
      chk(rx_full == 1'b0, "R1", "no completion from aborted frame", rx_full, 0);
      xact(16'h0033, 8, 16'h00AA, 16'h0033, "R1");

      // R10: back-to-back frames with a reload in flight
      load_tx(16'h0011);
      exp_q.push_back(16'h00C1); tag_q.push_back("R10");
      exp_q.push_back(16'h005E); tag_q.push_back("R10");
      sel_lo();
      load_tx(16'h0022);
      frame(16'h00C1, 8, 16, 1'b0, g1);
      frame(16'h005E, 8, 16, 1'b0, g2);
      sel_hi();
      chk(g1 == 16'h0011, "R10", "first frame output", g1, 16'h0011);
      chk(g2 == 16'h0022, "R10", "reloaded frame output", g2, 16'h0022);

      // R8: single-wire listen, then single-wire drive (loopback)
      cfg_single_wire = 1'b1; cfg_bidi_oe = 1'b0;
      load_tx(16'h0077);
      exp_q.push_back(16'h0096); tag_q.push_back("R8");
      sel_lo();
      chk(pad_io_oe == 1'b0, "R8", "listen mode leaves pin undriven", pad_io_oe, 0);
      frame(16'h0096, 8, 16, 1'b1, g1);
      sel_hi();
      cfg_bidi_oe = 1'b1;
      load_tx(16'h004D);
      exp_q.push_back(16'h004D); tag_q.push_back("R8");
      sel_lo();
      chk(pad_io_oe == 1'b1, "R8", "drive mode enables pin", pad_io_oe, 1);
      frame(16'h0000, 8, 16, 1'b1, g1);
      sel_hi();
      chk(g1 == 16'h004D, "R8", "single-wire output word", g1, 16'h004D);
      cfg_single_wire = 1'b0; cfg_bidi_oe = 1'b0;

      wait_clk(20);
      chk(exp_q.size() == 0, "R7", "all expected frames seen", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule